// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive byte stream of an Ethernet MAC and decides, for each frame, whether it should be kept. It watches the first six bytes of every frame, which carry the destination address. One cycle after the sixth byte it raises a decision strobe with an accept flag and a reason code. Descriptor handling and frame storage sit downstream and use the decision; this block only classifies.

Four tests are tried in a fixed priority. Promiscuous mode takes everything. After it come an exact match against the programmed station address, the all-ones broadcast address, and a 64-bin multicast hash. The hash bin comes from a reflected CRC-32 of the destination, computed on the fly as bytes arrive. A frame that ends before its sixth byte is rejected as short. A cleared receive enable rejects every frame.

Top module: `rxaddr_filter`

## Requirements
- R1: When `cfg_rx` bit 0 (receive enable) is 0 at the deciding byte, the decision is reject with reason code 5 (disabled), whatever the address or other settings.
- R2: With reception enabled and `cfg_rx` bit 6 (promiscuous) set, every frame of six or more bytes is accepted with reason code 1.
- R3: Destination byte i (0 first on the wire) is compared with station word i/2 (`cfg_station[16*(i/2) +: 16]`). The even byte is compared with bits 15:8 and the odd byte with bits 7:0. A full match accepts with reason code 2.
- R4: A destination of six 0xFF bytes is accepted with reason code 3.
- R5: The hash index is bits 31:26 of a CRC over the six destination bytes. The CRC register starts at 0xFFFFFFFF, uses the reflected polynomial 0xEDB88320, takes each byte least significant bit first and gets no final inversion. With `cfg_rx` bit 11 set, bit `index` of `cfg_hash` decides: index bits 5:4 pick word `cfg_hash[16*k +: 16]` and bits 3:0 pick the bit. A 1 accepts with reason code 4.
- R6: An enabled frame matching none of the tests is rejected with reason code 0. This covers a cleared hash bit, and also hash enable clear with every table bit set.
- R7: The tests take priority in this order: promiscuous, station, broadcast, hash.
- R8: `dec_valid` pulses for exactly one cycle, one clock after the sixth byte of a frame is accepted. Bytes 7 and later raise no further strobe. `dec_accept` is 1 only while `dec_valid` is 1.
- R9: If `in_eof` comes with a byte before the sixth, `dec_valid` pulses one clock later with reject and reason code 6 (short), provided reception is enabled.
- R10: A byte with `in_sof` always starts a new frame and drops any unfinished one without a decision. Bytes outside a frame cause no decision.
- R11: After reset `dec_valid`, `dec_accept` and `dec_reason` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is present on `in_data` this cycle |
| in_sof | input | 1 | The byte is the first of a frame |
| in_eof | input | 1 | The byte is the last of a frame |
| in_data | input | 8 | Received byte |
| cfg_rx | input | CFG_W | Receive settings: bit 0 enable, bit 6 promiscuous, bit 11 hash enable |
| cfg_station | input | ADDR_BYTES*8 | Station address as three 16-bit words, high byte first |
| cfg_hash | input | HASH_WORDS*WORD_W | Multicast hash table, word k at bits 16k+15:16k |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_reason | output | 3 | 0 none, 1 promiscuous, 2 station, 3 broadcast, 4 hash, 5 disabled, 6 short |

## Verification
The hardest case to reach is a hash accept. It needs a destination whose CRC lands on the one table bit that is set, and random addresses hit a chosen single bit only once in 64 tries. The bench therefore computes the CRC index of each chosen destination with its own bitwise model. It then sets or clears exactly that bin, so hits and misses in both halves of the table are provoked on purpose. A second case is an unfinished frame cut off by a fresh start marker. Directed sequences cover it, and the random runs mix frame lengths from one to twelve bytes with idle gaps inside the frame.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   localparam int CRC_W          = 32;
   localparam int CFG_EN_BIT     = 0;
   localparam int CFG_PROMISC_BIT = 6;
   localparam int CFG_HASH_BIT   = 11;

   typedef enum logic [2:0] {
      RSN_NONE     = 3'd0,
      RSN_PROMISC  = 3'd1,
      RSN_STATION  = 3'd2,
      RSN_BCAST    = 3'd3,
      RSN_HASH     = 3'd4,
      RSN_DISABLED = 3'd5,
      RSN_SHORT    = 3'd6
   } rsn_e;

   // one byte through a reflected CRC, low bit first
   function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                 input logic [7:0]       b,
                                                 input logic [CRC_W-1:0] poly);
      logic [CRC_W-1:0] r;
      r = c ^ {{(CRC_W-8){1'b0}}, b};
      for (int k = 0; k < 8; k++) begin
         r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
      end
      return r;
   endfunction

endpackage

// File: rtl/rxf_capture.sv
module rxf_capture #(
   parameter int ADDR_BYTES = 6,
   localparam int IDX_W = $clog2(ADDR_BYTES + 1),
   localparam int DST_W = ADDR_BYTES * 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sof,
   input  logic             in_eof,
   input  logic [7:0]       in_data,
   output logic             take,
   output logic             first,
   output logic             last_hit,
   output logic             short_hit,
   output logic [DST_W-1:0] dst_now
);

   logic             active_q;
   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] pos;
   logic [DST_W-1:0] dst_q;

   assign take      = in_valid && (in_sof || active_q);
   assign first     = in_valid && in_sof;
   assign pos       = in_sof ? '0 : idx_q;
   assign last_hit  = take && (pos == IDX_W'(ADDR_BYTES - 1));
   assign short_hit = take && in_eof && !last_hit;

   for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_byte
      assign dst_now[i*8 +: 8] = (take && (pos == IDX_W'(i))) ? in_data
                                                               : dst_q[i*8 +: 8];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         idx_q    <= '0;
         dst_q    <= '0;
      end else if (take) begin
         dst_q    <= dst_now;
         idx_q    <= pos + IDX_W'(1);
         active_q <= !(last_hit || short_hit);
      end
   end

endmodule

// File: rtl/rxf_crc_acc.sv
module rxf_crc_acc
   import rxf_pkg::*;
#(
   parameter logic [CRC_W-1:0] POLY = 32'hEDB88320,
   parameter logic [CRC_W-1:0] INIT = 32'hFFFFFFFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             first,
   input  logic [7:0]       in_data,
   output logic [CRC_W-1:0] crc_now
);

   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] base;

   assign base    = first ? INIT : crc_q;
   assign crc_now = crc_step(base, in_data, POLY);

   always_ff @(posedge clk) begin
      if (!rst_n) crc_q <= INIT;
      else if (take) crc_q <= crc_now;
   end

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
   import rxf_pkg::*;
#(
   parameter int ADDR_BYTES = 6,
   parameter int WORD_W     = 16,
   parameter int HASH_WORDS = 4,
   localparam int DST_W      = ADDR_BYTES * 8,
   localparam int BPW        = WORD_W / 8,
   localparam int HASH_N     = HASH_WORDS * WORD_W,
   localparam int HASH_IDX_W = $clog2(HASH_N)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  last_hit,
   input  logic                  short_hit,
   input  logic                  en,
   input  logic                  promisc,
   input  logic                  hash_en,
   input  logic [DST_W-1:0]      cfg_station,
   input  logic [HASH_N-1:0]     cfg_hash,
   input  logic [DST_W-1:0]      dst_now,
   input  logic [HASH_IDX_W-1:0] hash_idx,
   output logic                  dec_valid,
   output logic                  dec_accept,
   output logic [2:0]            dec_reason
);

   logic [ADDR_BYTES-1:0] sta_eq;
   logic [ADDR_BYTES-1:0] ones;
   logic                  hash_hit;
   rsn_e                  rsn_next;
   logic                  fire;

   for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_cmp
      localparam int WRD = i / BPW;
      localparam int OFF = (BPW - 1 - (i % BPW)) * 8;
      assign sta_eq[i] = dst_now[i*8 +: 8] == cfg_station[WRD*WORD_W + OFF +: 8];
      assign ones[i]   = &dst_now[i*8 +: 8];
   end

   assign hash_hit = cfg_hash[hash_idx];
   assign fire     = last_hit || short_hit;

   always_comb begin
      if (!en)                     rsn_next = RSN_DISABLED;
      else if (short_hit)          rsn_next = RSN_SHORT;
      else if (promisc)            rsn_next = RSN_PROMISC;
      else if (&sta_eq)            rsn_next = RSN_STATION;
      else if (&ones)              rsn_next = RSN_BCAST;
      else if (hash_en && hash_hit) rsn_next = RSN_HASH;
      else                         rsn_next = RSN_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_valid  <= 1'b0;
         dec_accept <= 1'b0;
         dec_reason <= '0;
      end else begin
         dec_valid  <= fire;
         dec_accept <= fire && (rsn_next inside {RSN_PROMISC, RSN_STATION,
                                                 RSN_BCAST, RSN_HASH});
         dec_reason <= fire ? rsn_next : RSN_NONE;
      end
   end

endmodule

// File: rtl/rxaddr_filter.sv
module rxaddr_filter
   import rxf_pkg::*;
#(
   parameter int               ADDR_BYTES   = 6,
   parameter int               WORD_W       = 16,
   parameter int               HASH_WORDS   = 4,
   parameter int               CFG_W        = 16,
   parameter logic [CRC_W-1:0] CRC_POLY     = 32'hEDB88320,
   parameter logic [CRC_W-1:0] CRC_INIT     = 32'hFFFFFFFF,
   parameter bit               CRC_PER_BYTE = 1'b1,
   localparam int DST_W      = ADDR_BYTES * 8,
   localparam int HASH_N     = HASH_WORDS * WORD_W,
   localparam int HASH_IDX_W = $clog2(HASH_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sof,
   input  logic              in_eof,
   input  logic [7:0]        in_data,
   input  logic [CFG_W-1:0]  cfg_rx,
   input  logic [DST_W-1:0]  cfg_station,
   input  logic [HASH_N-1:0] cfg_hash,
   output logic              dec_valid,
   output logic              dec_accept,
   output logic [2:0]        dec_reason
);

   if (WORD_W % 8 != 0) begin : g_bad_word
      $error("WORD_W must be a whole number of bytes");
   end
   if (DST_W % WORD_W != 0) begin : g_bad_sta
      $error("address must fill whole station words");
   end
   if ((1 << HASH_IDX_W) != HASH_N) begin : g_bad_hash
      $error("hash table size must be a power of two");
   end
   if (HASH_IDX_W > CRC_W) begin : g_bad_idx
      $error("hash index wider than the CRC");
   end
   if (CFG_W <= CFG_HASH_BIT) begin : g_bad_cfg
      $error("receive config too narrow");
   end

   logic             take, first, last_hit, short_hit;
   logic [DST_W-1:0] dst_now;
   logic [CRC_W-1:0] crc_now;
   logic             unused_cfg;

   assign unused_cfg = ^cfg_rx;

   rxf_capture #(.ADDR_BYTES(ADDR_BYTES)) u_capture (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_sof    (in_sof),
      .in_eof    (in_eof),
      .in_data   (in_data),
      .take      (take),
      .first     (first),
      .last_hit  (last_hit),
      .short_hit (short_hit),
      .dst_now   (dst_now)
   );

   if (CRC_PER_BYTE) begin : g_crc_acc
      rxf_crc_acc #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
         .clk     (clk),
         .rst_n   (rst_n),
         .take    (take),
         .first   (first),
         .in_data (in_data),
         .crc_now (crc_now)
      );
   end else begin : g_crc_fold
      always_comb begin
         crc_now = CRC_INIT;
         for (int i = 0; i < ADDR_BYTES; i++) begin
            crc_now = crc_step(crc_now, dst_now[i*8 +: 8], CRC_POLY);
         end
      end
   end

   logic unused_crc_lo;
   assign unused_crc_lo = ^crc_now[CRC_W-HASH_IDX_W-1:0];

   rxf_decide #(
      .ADDR_BYTES (ADDR_BYTES),
      .WORD_W     (WORD_W),
      .HASH_WORDS (HASH_WORDS)
   ) u_decide (
      .clk         (clk),
      .rst_n       (rst_n),
      .last_hit    (last_hit),
      .short_hit   (short_hit),
      .en          (cfg_rx[CFG_EN_BIT]),
      .promisc     (cfg_rx[CFG_PROMISC_BIT]),
      .hash_en     (cfg_rx[CFG_HASH_BIT]),
      .cfg_station (cfg_station),
      .cfg_hash    (cfg_hash),
      .dst_now     (dst_now),
      .hash_idx    (crc_now[CRC_W-1 -: HASH_IDX_W]),
      .dec_valid   (dec_valid),
      .dec_accept  (dec_accept),
      .dec_reason  (dec_reason)
   );

endmodule

// File: rtl/rxaddr_filter_chk.sv
module rxaddr_filter_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic       in_eof,
   input logic       cfg_en,
   input logic       cfg_promisc,
   input logic       dec_valid,
   input logic       dec_accept,
   input logic [2:0] dec_reason
);

   AST_OFF_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid && !$past(cfg_en) |-> !dec_accept && dec_reason == 3'd5); // R1

   AST_PROMISC_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid && $past(cfg_en && cfg_promisc) && dec_reason != 3'd6
      |-> dec_accept && dec_reason == 3'd1); // R2

   AST_STROBE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> $past(in_valid)); // R8

   AST_ACCEPT_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      dec_accept |-> dec_valid); // R8

   AST_SHORT_NEEDS_EOF: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid && dec_reason == 3'd6 |-> $past(in_eof) && !dec_accept); // R9

endmodule

bind rxaddr_filter rxaddr_filter_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_eof      (in_eof),
   .cfg_en      (cfg_rx[0]),
   .cfg_promisc (cfg_rx[6]),
   .dec_valid   (dec_valid),
   .dec_accept  (dec_accept),
   .dec_reason  (dec_reason)
);

// File: tb/rxaddr_filter_bench.sv
module rxaddr_filter_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
   logic [7:0]  in_data = 8'd0;
   logic [15:0] cfg_rx = 16'd0;
   logic [47:0] cfg_station = 48'd0;
   logic [63:0] cfg_hash = 64'd0;
   logic        dec_valid, dec_accept;
   logic [2:0]  dec_reason;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   rxaddr_filter u_rxaddr_filter (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .in_eof(in_eof), .in_data(in_data), .cfg_rx(cfg_rx),
      .cfg_station(cfg_station), .cfg_hash(cfg_hash),
      .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_reason(dec_reason)
   );

   localparam logic [15:0] EN = 16'h0001, PM = 16'h0040, HE = 16'h0800;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // bitwise reference CRC: feed bit by bit, low bit of each byte first
   function automatic logic [5:0] ref_index(input logic [47:0] d);
      logic [31:0] c = 32'hFFFFFFFF;
      for (int i = 0; i < 48; i++) begin
         logic fb;
         fb = c[0] ^ d[i];
         c = {1'b0, c[31:1]};
         if (fb) c = c ^ 32'hEDB88320;
      end
      return c[31:26];
   endfunction

   function automatic logic [47:0] sta_as_dst(input logic [47:0] s);
      logic [47:0] d;
      for (int w = 0; w < 3; w++) begin
         d[(2*w)*8 +: 8]   = s[w*16+8 +: 8];
         d[(2*w+1)*8 +: 8] = s[w*16 +: 8];
      end
      return d;
   endfunction

   function automatic logic [2:0] model(input logic [15:0] rx, input logic [47:0] sta,
                                        input logic [63:0] hsh, input logic [47:0] d,
                                        input bit short_f);
      logic [5:0] ix;
      if (!rx[0]) return 3'd5;
      if (short_f) return 3'd6;
      if (rx[6]) return 3'd1;
      if (d == sta_as_dst(sta)) return 3'd2;
      if (d == {48{1'b1}}) return 3'd3;
      ix = ref_index(d);
      if (rx[11] && hsh[{ix[5:4], 4'd0} + ix[3:0]]) return 3'd4;
      return 3'd0;
   endfunction

   task automatic put(input logic [7:0] d, input bit v, input bit s, input bit e);
      in_data = d; in_valid = v; in_sof = s; in_eof = e;
      @(negedge clk);
   endtask

   task automatic send(input logic [47:0] d, input int n, input bit gaps, input string req);
      logic [2:0] er;
      for (int i = 0; i < n; i++) begin
         put(i < 6 ? d[i*8 +: 8] : 8'($urandom), 1'b1, i == 0, i == n - 1);
         if (i == 5 || (i < 5 && i == n - 1)) begin
            er = model(cfg_rx, cfg_station, cfg_hash, d, i < 5);
            chk({req, " strobe"}, dec_valid, 1);
            chk({req, " reason"}, dec_reason, er);
            chk({req, " accept"}, dec_accept, (er >= 3'd1 && er <= 3'd4));
         end else begin
            chk({req, " R8 no strobe"}, dec_valid, 0);
         end
         if (gaps && ($urandom % 4 == 0)) begin
            put(8'h00, 1'b0, 1'b0, 1'b0);
            chk({req, " R8 quiet gap"}, dec_valid, 0);
         end
      end
      put(8'h00, 1'b0, 1'b0, 1'b0);
      chk({req, " R8 single pulse"}, dec_valid, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [47:0] d;
      logic [5:0]  ix;
      void'($urandom(32'h1d2c3b4a));
      repeat (3) @(negedge clk);
      chk("R11 valid", dec_valid, 0);
      chk("R11 accept", dec_accept, 0);
      chk("R11 reason", dec_reason, 0);
      rst_n = 1'b1;
      @(negedge clk);

      cfg_station = 48'h0A0B_0C0D_0E0F;   // word2=0A0B word1=0C0D word0=0E0F
      cfg_hash    = '0;

      // R1: disabled, even with promiscuous set
      cfg_rx = PM | HE;
      send(48'hFFFFFFFFFFFF, 6, 0, "R1");
      send(sta_as_dst(cfg_station), 3, 0, "R1 short");

      // R2
      cfg_rx = EN | PM;
      send(48'h123456789ABC, 8, 0, "R2");

      // R3 exact match and swapped byte order
      cfg_rx = EN;
      send(sta_as_dst(cfg_station), 6, 0, "R3");
      d = sta_as_dst(cfg_station);
      send({d[39:0], d[47:40]}, 6, 0, "R3 order");
      send({d[47:8], d[7:0] ^ 8'h01}, 6, 0, "R3 miss");

      // R4
      send(48'hFFFFFFFFFFFF, 7, 0, "R4");

      // R5 / R6 hash hits and misses, both table halves
      for (int k = 0; k < 12; k++) begin
         d = {$urandom, $urandom} | 48'h1;   // group bit set
         ix = ref_index(d);
         cfg_rx = EN | HE;
         cfg_hash = '0; cfg_hash[ix] = 1'b1;
         send(d, 6, 0, "R5 hit");
         cfg_hash = ~cfg_hash;
         send(d, 6, 0, "R6 miss");
         cfg_rx = EN;
         cfg_hash = '1;
         send(d, 6, 0, "R6 hash off");
      end

      // R7 priority
      cfg_rx = EN | PM | HE; cfg_hash = '1;
      send(sta_as_dst(cfg_station), 6, 0, "R7 promisc first");
      cfg_rx = EN | HE; cfg_station = '1;
      send(48'hFFFFFFFFFFFF, 6, 0, "R7 station before bcast");
      cfg_station = 48'h0A0B_0C0D_0E0F;
      send(48'hFFFFFFFFFFFF, 6, 0, "R7 bcast before hash");
      send(sta_as_dst(cfg_station), 6, 0, "R7 station before hash");

      // R8 long frame, R9 short frames
      cfg_rx = EN; cfg_hash = '0;
      send(sta_as_dst(cfg_station), 12, 1, "R8");
      cfg_rx = EN | PM;
      for (int n = 1; n <= 5; n++) send(48'hFFFFFFFFFFFF, n, 0, "R9");

      // R10 stray bytes and an abandoned frame
      cfg_rx = EN;
      for (int i = 0; i < 4; i++) begin
         put(8'hFF, 1'b1, 1'b0, 1'b0);
         chk("R10 stray", dec_valid, 0);
      end
      put(8'hFF, 1'b1, 1'b1, 1'b0);
      chk("R10 partial", dec_valid, 0);
      for (int i = 0; i < 3; i++) begin
         put(8'hFF, 1'b1, 1'b0, 1'b0);
         chk("R10 partial", dec_valid, 0);
      end
      send(sta_as_dst(cfg_station), 6, 0, "R10 restart");

      // random mix
      for (int t = 0; t < 400; t++) begin
         cfg_station = {$urandom, $urandom};
         cfg_hash    = {$urandom, $urandom};
         cfg_rx      = 16'($urandom) & ~16'h0041;
         if ($urandom % 10 != 0) cfg_rx |= EN;
         if ($urandom % 8 == 0)  cfg_rx |= PM;
         case ($urandom % 4)
            0: d = sta_as_dst(cfg_station);
            1: d = 48'hFFFFFFFFFFFF;
            2: d = sta_as_dst(cfg_station) ^ (48'h1 << ($urandom % 48));
            default: d = {$urandom, $urandom};
         endcase
         send(d, 1 + ($urandom % 12), 1, "R7 random");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule